// File: doc/BRIEF.md
# Retransmit-Capable FIFO Read Controller

This block holds a small single-clock FIFO and the pointer logic that lets a receiver replay a packet. Words are pushed through a write port and popped through a read port whose data output always shows the word at the head. When the active-low rewind input is sampled low, the read pointer returns to physical location zero, so every word stored since reset can be read out again. Reads then proceed normally until the read pointer meets the write pointer, and any words written after the rewind are delivered in order behind the replayed ones.

A rewind is honoured only in the standard operating mode and only while the number of words written since reset stays below the depth minus a guard value that depends on the selected word size. Reads are locked out while the rewind input is low and for a recovery window afterwards. A read attempted in that window is dropped and flagged on an error output.

Top module: `rtx_fifo_ctrl`

## Requirements
- R1: After reset both pointers are zero, empty_o is 1, full_o is 0, rt_invalid_o is 0 and rd_err_o is 0.
- R2: A write with full_o low stores wr_data_i and advances wr_ptr_o by one at the next edge; full_o is 1 when the address bits of both pointers match and their top (wrap) bits differ, and a write while full_o is 1 leaves wr_ptr_o unchanged.
- R3: A read with empty_o low and no lockout advances rd_ptr_o by one, rd_data_o shows the words in write order, and a read while empty_o is 1 leaves rd_ptr_o unchanged.
- R4: When rt_ni is sampled low with std_mode_i high and rt_invalid_o low, rd_ptr_o is zero after that edge and rd_data_o shows the first word written since reset.
- R5: empty_o and full_o follow the pointers in the same cycle as the rewind, so a FIFO that was read empty reports empty_o low right after an honoured rewind.
- R6: After a rewind, reads return the stored words from location zero onward, followed by words written after the rewind, and empty_o rises when rd_ptr_o equals wr_ptr_o.
- R7: Reads are locked out on each edge where an honoured rewind is sampled and on the RECOV (default 2) edges after rt_ni returns high; a read attempted then leaves rd_ptr_o unchanged and sets rd_err_o to 1 for the following cycle.
- R8: rt_invalid_o is 1 while the number of words written since reset is at least DEPTH minus the guard, the guard being 2 for width_sel_i 2'b00 (36-bit words), 4 for 2'b01 (18-bit) and 8 for 2'b10 or 2'b11 (9-bit).
- R9: A low rt_ni is ignored when std_mode_i is 0 or rt_invalid_o is 1: rd_ptr_o keeps its value and no read lockout is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| std_mode_i | input | 1 | Standard mode; rewind only allowed when 1 |
| width_sel_i | input | 2 | Word size code selecting the rewind guard |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DW | Write data |
| rd_en_i | input | 1 | Read request |
| rt_ni | input | 1 | Rewind request, active low |
| rd_data_o | output | DW | Word at the read pointer |
| wr_ptr_o | output | AW+1 | Write pointer with wrap bit |
| rd_ptr_o | output | AW+1 | Read pointer with wrap bit |
| empty_o | output | 1 | Pointers equal |
| full_o | output | 1 | Addresses equal, wrap bits differ |
| rt_invalid_o | output | 1 | Too many words written for a rewind |
| rd_err_o | output | 1 | A read was dropped during lockout |

## Verification
Pointers and rd_err_o change on the edge that samples the request, so the bench drives inputs on the falling edge and reads results on the next falling edge, one full cycle later. empty_o, full_o and rt_invalid_o are decoded from registers and are due in that same cycle, while rd_data_o follows the read pointer combinationally and is checked at a falling edge before the pop that consumes it. The lockout is checked edge by edge: the sampled-low edge and the two after it must hold rd_ptr_o at zero with rd_err_o set, and the fourth edge must clear rd_err_o. Every word count from one up to the guard limit is swept for each word-size code, with expected data computed from the count and index.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;

  // word-size code -> words that must remain unwritten for a rewind
  function automatic int unsigned guard_words(input logic [1:0] sel);
    case (sel)
      2'b00:   return 2;
      2'b01:   return 4;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/rtx_store.sv
module rtx_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rtx_wr_ctrl.sv
module rtx_wr_ctrl
  import rtx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        full_i,
  input  logic [1:0]  width_sel_i,
  output logic        push_o,
  output logic [AW:0] wr_ptr_o,
  output logic        rt_invalid_o
);
  logic [AW:0]   ptr_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign push_o = wr_en_i && !full_i;
  assign limit  = CW'(DEPTH - guard_words(width_sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push_o) begin
      ptr_q <= ptr_q + 1'b1;
      // count since reset saturates; only the threshold matters
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wr_ptr_o     = ptr_q;
  assign rt_invalid_o = (cnt_q >= limit);
endmodule

// File: rtl/rtx_rd_ctrl.sv
module rtx_rd_ctrl #(
  parameter int DEPTH = 16,
  parameter int RECOV = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int RW   = $clog2(RECOV + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_en_i,
  input  logic        empty_i,
  input  logic        rt_ni,
  input  logic        rt_allow_i,
  output logic [AW:0] rd_ptr_o,
  output logic        rd_err_o
);
  logic [AW:0]   ptr_q;
  logic [RW-1:0] rec_q;
  logic          err_q;
  logic          rt_take, blocked, pop;

  assign rt_take = !rt_ni && rt_allow_i;
  assign blocked = rt_take || (rec_q != '0);
  assign pop     = rd_en_i && !empty_i && !blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      rec_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (rt_take)  ptr_q <= '0;
      else if (pop) ptr_q <= ptr_q + 1'b1;

      if (rt_take)            rec_q <= RW'(RECOV);
      else if (rec_q != '0)   rec_q <= rec_q - 1'b1;

      err_q <= rd_en_i && blocked;
    end
  end

  assign rd_ptr_o = ptr_q;
  assign rd_err_o = err_q;
endmodule

// File: rtl/rtx_flags.sv
module rtx_flags #(
  parameter int AW = 4
) (
  input  logic [AW:0] wr_ptr_i,
  input  logic [AW:0] rd_ptr_i,
  output logic        empty_o,
  output logic        full_o
);
  assign empty_o = (wr_ptr_i == rd_ptr_i);
  assign full_o  = (wr_ptr_i[AW-1:0] == rd_ptr_i[AW-1:0]) &&
                   (wr_ptr_i[AW] != rd_ptr_i[AW]);
endmodule

// File: rtl/rtx_fifo_ctrl.sv
module rtx_fifo_ctrl #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int RECOV = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          std_mode_i,
  input  logic [1:0]    width_sel_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic          rt_ni,
  output logic [DW-1:0] rd_data_o,
  output logic [AW:0]   wr_ptr_o,
  output logic [AW:0]   rd_ptr_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          rt_invalid_o,
  output logic          rd_err_o
);
  logic push;
  logic rt_allow;

  assign rt_allow = std_mode_i && !rt_invalid_o;

  rtx_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .full_i       (full_o),
    .width_sel_i  (width_sel_i),
    .push_o       (push),
    .wr_ptr_o     (wr_ptr_o),
    .rt_invalid_o (rt_invalid_o)
  );

  rtx_rd_ctrl #(.DEPTH(DEPTH), .RECOV(RECOV)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .empty_i    (empty_o),
    .rt_ni      (rt_ni),
    .rt_allow_i (rt_allow),
    .rd_ptr_o   (rd_ptr_o),
    .rd_err_o   (rd_err_o)
  );

  rtx_flags #(.AW(AW)) u_flags (
    .wr_ptr_i (wr_ptr_o),
    .rd_ptr_i (rd_ptr_o),
    .empty_o  (empty_o),
    .full_o   (full_o)
  );

  rtx_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (push),
    .waddr_i (wr_ptr_o[AW-1:0]),
    .wdata_i (wr_data_i),
    .raddr_i (rd_ptr_o[AW-1:0]),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/rtx_fifo_ctrl_chk.sv
module rtx_fifo_ctrl_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          std_mode_i,
  input logic [1:0]    width_sel_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          rt_ni,
  input logic [AW:0]   wr_ptr_o,
  input logic [AW:0]   rd_ptr_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          rt_invalid_o,
  input logic          rd_err_o
);
  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> $stable(wr_ptr_o));

  assert_full_ptrs_differ_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (wr_ptr_o != rd_ptr_o));

  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && empty_o && rt_ni) |=> $stable(rd_ptr_o));

  assert_rewind_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rt_ni && std_mode_i && !rt_invalid_o) |=> (rd_ptr_o == '0));

  assert_flags_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));

  assert_lockout_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rt_ni && std_mode_i && !rt_invalid_o && rd_en_i) |=> rd_err_o);

  assert_invalid_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_invalid_o ##1 $stable(width_sel_i)) |-> rt_invalid_o);

  assert_ignored_rewind_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rt_ni && !std_mode_i && !rd_en_i) |=> $stable(rd_ptr_o));
endmodule

bind rtx_fifo_ctrl rtx_fifo_ctrl_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/rtx_fifo_ctrl_test.sv
module rtx_fifo_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          std_mode;
  logic [1:0]    width_sel;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic          rd_en;
  logic          rt_n;
  logic [DW-1:0] rd_data;
  logic [AW:0]   wr_ptr, rd_ptr;
  logic          empty, full, rt_invalid, rd_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rtx_fifo_ctrl #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .std_mode_i(std_mode), .width_sel_i(width_sel),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rt_ni(rt_n),
    .rd_data_o(rd_data), .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .empty_o(empty),
    .full_o(full), .rt_invalid_o(rt_invalid), .rd_err_o(rd_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rt_n = 1'b1;
    wr_data = '0; std_mode = 1'b1; width_sel = 2'b00;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic push(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pop_chk(input logic [DW-1:0] exp, input string req);
    check(req, "rd_data", 32'(rd_data), 32'(exp));
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  function automatic logic [DW-1:0] dat(input int n, input int i);
    return DW'((n << 4) | i);
  endfunction

  function automatic int guard_of(input int sel);
    return (sel == 0) ? 2 : (sel == 1) ? 4 : 8;
  endfunction

  task automatic run_case(input int sel, input int n);
    int limit, k, start;
    bit valid;
    logic [DW-1:0] extra;
    limit = DEPTH - guard_of(sel);
    valid = (n < limit);
    k     = (n % 3 == 0) ? n : n / 2;
    extra = DW'(8'hE0 | n);
    do_reset();
    width_sel = 2'(sel);
    for (int i = 0; i < n; i++) push(dat(n, i));
    check("R8", "rt_invalid", 32'(rt_invalid), 32'(!valid));
    check("R2", "wr_ptr", 32'(wr_ptr), 32'(n));
    for (int i = 0; i < k; i++) pop_chk(dat(n, i), "R3");
    check("R3", "rd_ptr", 32'(rd_ptr), 32'(k));
    check("R3", "empty", 32'(empty), 32'(k == n));
    rt_n = 1'b0; rd_en = valid;
    tick();
    if (valid) begin
      check("R4", "rd_ptr", 32'(rd_ptr), 0);
      check("R5", "empty", 32'(empty), 0);
      check("R4", "rd_data", 32'(rd_data), 32'(dat(n, 0)));
      check("R7", "rd_err", 32'(rd_err), 1);
      rt_n = 1'b1; rd_en = 1'b1;
      tick();
      check("R7", "rd_ptr", 32'(rd_ptr), 0);
      tick();
      check("R7", "rd_ptr", 32'(rd_ptr), 0);
      check("R7", "rd_err", 32'(rd_err), 1);
      rd_en = 1'b0;
      tick();
      check("R7", "rd_err", 32'(rd_err), 0);
    end else begin
      check("R9", "rd_ptr", 32'(rd_ptr), 32'(k));
      rt_n = 1'b1;
      tick();
    end
    push(extra);
    start = valid ? 0 : k;
    for (int i = start; i < n; i++) pop_chk(dat(n, i), "R6");
    pop_chk(extra, "R6");
    check("R6", "empty", 32'(empty), 1);
    check("R6", "rd_ptr", 32'(rd_ptr), 32'(n + 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1", "wr_ptr", 32'(wr_ptr), 0);
    check("R1", "rd_ptr", 32'(rd_ptr), 0);
    check("R1", "empty", 32'(empty), 1);
    check("R1", "full", 32'(full), 0);
    check("R1", "rt_invalid", 32'(rt_invalid), 0);
    check("R1", "rd_err", 32'(rd_err), 0);

    // R3 read on empty is dropped
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    check("R3", "rd_ptr empty read", 32'(rd_ptr), 0);

    // R2 fill to full, extra write dropped
    for (int i = 0; i < DEPTH; i++) push(DW'(8'h40 + i));
    check("R2", "full", 32'(full), 1);
    check("R2", "wr_ptr", 32'(wr_ptr), 32'(DEPTH));
    push(8'hFF);
    check("R2", "wr_ptr after full write", 32'(wr_ptr), 32'(DEPTH));
    check("R8", "rt_invalid", 32'(rt_invalid), 1);
    pop_chk(8'h40, "R3");
    check("R2", "full after read", 32'(full), 0);

    // R9 rewind ignored outside standard mode
    do_reset();
    for (int i = 0; i < 4; i++) push(dat(4, i));
    pop_chk(dat(4, 0), "R3");
    pop_chk(dat(4, 1), "R3");
    std_mode = 1'b0; rt_n = 1'b0;
    tick();
    check("R9", "rd_ptr", 32'(rd_ptr), 2);
    rt_n = 1'b1;
    pop_chk(dat(4, 2), "R9");
    check("R9", "rd_ptr no lockout", 32'(rd_ptr), 3);
    check("R9", "rd_err", 32'(rd_err), 0);
    std_mode = 1'b1;

    // sweep every word count per word-size code
    for (int sel = 0; sel < 3; sel++)
      for (int n = 1; n <= DEPTH - guard_of(sel); n++) run_case(sel, n);

    // R8 code 3 uses the narrow guard
    do_reset();
    width_sel = 2'b11;
    for (int i = 0; i < DEPTH - 9; i++) push(DW'(i));
    check("R8", "rt_invalid sel3 below", 32'(rt_invalid), 0);
    push(8'h77);
    check("R8", "rt_invalid sel3 at", 32'(rt_invalid), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule